// File: doc/BRIEF.md
# Page-Protection Entry Register Slice

This block is the slice of a 64-bit core's system-coprocessor register file that holds the page-protection state. It has one 32-bit page-granularity control word and two 64-bit TLB entry-low words. The control word contains two enable flags. Bit 31 permits the read-inhibit protection bit and bit 30 permits the execute-inhibit protection bit. In each entry word the read-inhibit bit sits at bit 63 and the execute-inhibit bit at bit 62.

Software reaches the registers through a single register/select address. A write strobe carries a qualifier that picks a 32-bit move or a 64-bit move. On a 32-bit move the protection bits arrive on write-data bits 31:30 and are lifted into entry bits 63:62. On a 64-bit move they arrive directly on bits 63:62. In both forms each protection bit is stored only if its enable flag is set. A 32-bit read of an entry word folds the two top bits back into bits 31:30 when inhibit support is configured. Every 32-bit read result is sign-extended to 64 bits.

A revision-profile input chooses how the enable flags behave. In the older profile they are writable when inhibit support is present. In the newer profile they are fixed at one. The reset value of the control word and its writable-bit mask are per-core parameters.

Top module: `pgprot_regs`

## Requirements
- R1: After reset both entry words read as zero, and the control word reads as the parameter CTL_RESET (with bits 31:30 forced to one in the newer profile).
- R2: A write to the control word (register 5, select 1) changes only the bits 29:0 that are set in the parameter CTL_WMASK. Every other bit of 29:0 keeps its value.
- R3: In the older profile (rev_new = 0), control bits 31:30 are writable when cfg_inh = 1. When cfg_inh = 0 they keep their value on any write.
- R4: In the newer profile (rev_new = 1), control bits 31:30 read as 1, act as 1 for gating, and writes do not change them.
- R5: A 32-bit move (wr_wide = 0) to an entry word stores write-data bits 29:0 unchanged. Write-data bit 31 goes to entry bit 63 only if control bit 31 is 1, and bit 30 goes to entry bit 62 only if control bit 30 is 1. Entry bits 61:30 are zero.
- R6: A 64-bit move (wr_wide = 1) to an entry word stores write-data bits 29:0. Write-data bits 63 and 62 are stored, gated by control bits 31 and 30 respectively. Entry bits 61:30 are zero.
- R7: A 32-bit read (rd_wide = 0) of an entry word returns entry bits 31:0, with bits 63:62 ORed into bits 31:30 when cfg_inh = 1 and not when cfg_inh = 0. The result is sign-extended from bit 31.
- R8: A 64-bit read (rd_wide = 1) of an entry word returns the full 64-bit value with no folding.
- R9: Entry-low 0 is register 2 select 0, and entry-low 1 is register 3 select 0. A read of any address other than these and the control word returns zero, and a write to such an address changes no register.
- R10: A write takes effect at the clock edge that samples wr_en. A read in the same cycle returns the old value.
- R11: A read of the control word returns its 32-bit value sign-extended to 64 bits, for both read widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_wide | input | 1 | 1 = 64-bit move, 0 = 32-bit move |
| addr_reg | input | 5 | Register number, shared by read and write |
| addr_sel | input | 3 | Select number, shared by read and write |
| wr_data | input | 64 | Write data |
| rd_wide | input | 1 | 1 = 64-bit read, 0 = 32-bit read (sign-extended) |
| cfg_inh | input | 1 | Inhibit-support flag, taken from bit 12 of the configuration word |
| rev_new | input | 1 | Revision profile: 1 = enable flags fixed at one |
| rd_data | output | 64 | Read data for the addressed register |

## Verification
The checker relies on a write and a read of the same address that follows it in the next cycle happening under an unchanged address. It also relies on the revision profile and the inhibit flag being quasi-static around the cycles it inspects. The stimulus changes rev_new and cfg_inh only in cycles that perform no register write. It holds each address for the whole cycle in which it is driven, so that the write and the readback of one entry use identical register/select values. Writes to unused addresses are always followed by reads of the real registers, so that any stray update shows at the read port.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

    localparam int XLEN    = 64;
    localparam int CTL_W   = 32;
    localparam int AREG_W  = 5;
    localparam int ASEL_W  = 3;
    localparam int LOW_W   = 30;
    localparam int INH_W   = 2;
    localparam int NUM_ENT = 2;
    localparam int GAP_W   = XLEN - INH_W - LOW_W;

    // enable flags in the control word; their position is what the entry gating decodes
    localparam int RIE_POS = 31;
    localparam int XIE_POS = 30;
    localparam logic [CTL_W-1:0] EN_FIELD = CTL_W'(2'b11) << XIE_POS;

    localparam logic [AREG_W-1:0] REG_ENT0 = AREG_W'(2);
    localparam logic [AREG_W-1:0] REG_ENT1 = AREG_W'(3);
    localparam logic [AREG_W-1:0] REG_CTL  = AREG_W'(5);
    localparam logic [ASEL_W-1:0] SEL_ENT  = ASEL_W'(0);
    localparam logic [ASEL_W-1:0] SEL_CTL  = ASEL_W'(1);

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ENT0 = 2'd1,
        TGT_ENT1 = 2'd2,
        TGT_CTL  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [INH_W-1:0] inh;
        logic [LOW_W-1:0] low;
    } ent_t;

    typedef struct packed {
        logic [CTL_W-1:0] val;
    } ctl_t;

    function automatic tgt_e decode_addr(input logic [AREG_W-1:0] r,
                                         input logic [ASEL_W-1:0] s);
        tgt_e t;
        t = TGT_NONE;
        if (r == REG_ENT0 && s == SEL_ENT) t = TGT_ENT0;
        if (r == REG_ENT1 && s == SEL_ENT) t = TGT_ENT1;
        if (r == REG_CTL  && s == SEL_CTL) t = TGT_CTL;
        return t;
    endfunction

    function automatic logic [XLEN-1:0] sext_word(input logic [CTL_W-1:0] v);
        return {{(XLEN-CTL_W){v[CTL_W-1]}}, v};
    endfunction

endpackage

// File: rtl/pgprot_ctl_reg.sv
module pgprot_ctl_reg
    import pgprot_pkg::*;
#(
    parameter logic [CTL_W-1:0] CTL_RESET = 32'h0000_0003,
    parameter logic [CTL_W-1:0] CTL_WMASK = 32'h1800_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wd,
    input  logic             inh_sup,
    input  logic             rev_new,
    output logic [CTL_W-1:0] ctl_eff
);

    localparam logic [CTL_W-1:0] BASE_MASK = CTL_WMASK & ~EN_FIELD;

    ctl_t             state_d, state_q;
    logic [CTL_W-1:0] mask_eff;

    always_comb begin
        mask_eff = BASE_MASK;
        if (!rev_new && inh_sup) begin
            mask_eff = BASE_MASK | EN_FIELD;
        end
        state_d = state_q;
        if (we) begin
            state_d.val = (wd & mask_eff) | (state_q.val & ~mask_eff);
        end
        ctl_eff = rev_new ? (state_q.val | EN_FIELD) : state_q.val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.val <= CTL_RESET;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pgprot_entry_reg.sv
module pgprot_entry_reg
    import pgprot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wide,
    input  logic [LOW_W-1:0] wd_low,
    input  logic [INH_W-1:0] wd_hi32,
    input  logic [INH_W-1:0] wd_hi64,
    input  logic [INH_W-1:0] en,
    output logic [XLEN-1:0]  val
);

    ent_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.low = wd_low;
            state_d.inh = (wide ? wd_hi64 : wd_hi32) & en;
        end
        val = {state_q.inh, {GAP_W{1'b0}}, state_q.low};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pgprot_rd_mux.sv
module pgprot_rd_mux
    import pgprot_pkg::*;
(
    input  tgt_e             tgt,
    input  logic             rd_wide,
    input  logic             fold_en,
    input  logic [XLEN-1:0]  ent0,
    input  logic [XLEN-1:0]  ent1,
    input  logic [CTL_W-1:0] ctl,
    output logic [XLEN-1:0]  rd_data
);

    logic [XLEN-1:0]  ent_sel;
    logic [CTL_W-1:0] narrow;

    always_comb begin
        ent_sel = (tgt == TGT_ENT1) ? ent1 : ent0;
        narrow  = ent_sel[CTL_W-1:0];
        if (fold_en) begin
            narrow = narrow | {ent_sel[XLEN-1 -: INH_W], {(CTL_W-INH_W){1'b0}}};
        end
        unique case (tgt)
            TGT_ENT0, TGT_ENT1: rd_data = rd_wide ? ent_sel : sext_word(narrow);
            TGT_CTL:            rd_data = sext_word(ctl);
            default:            rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pgprot_regs.sv
module pgprot_regs
    import pgprot_pkg::*;
#(
    parameter logic [CTL_W-1:0] CTL_RESET = 32'h0000_0003,
    parameter logic [CTL_W-1:0] CTL_WMASK = 32'h1800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [AREG_W-1:0] addr_reg,
    input  logic [ASEL_W-1:0] addr_sel,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              rd_wide,
    input  logic              cfg_inh,
    input  logic              rev_new,
    output logic [XLEN-1:0]   rd_data
);

    tgt_e             tgt;
    logic [CTL_W-1:0] ctl_eff;
    logic [XLEN-1:0]  ent_val [NUM_ENT];

    assign tgt = decode_addr(addr_reg, addr_sel);

    pgprot_ctl_reg #(
        .CTL_RESET (CTL_RESET),
        .CTL_WMASK (CTL_WMASK)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && (tgt == TGT_CTL)),
        .wd      (wr_data[CTL_W-1:0]),
        .inh_sup (cfg_inh),
        .rev_new (rev_new),
        .ctl_eff (ctl_eff)
    );

    for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_ent
        localparam tgt_e MY_TGT = tgt_e'(2'(gi + 1));
        pgprot_entry_reg u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_en && (tgt == MY_TGT)),
            .wide    (wr_wide),
            .wd_low  (wr_data[LOW_W-1:0]),
            .wd_hi32 (wr_data[RIE_POS:XIE_POS]),
            .wd_hi64 (wr_data[XLEN-1 -: INH_W]),
            .en      (ctl_eff[RIE_POS:XIE_POS]),
            .val     (ent_val[gi])
        );
    end

    pgprot_rd_mux u_rd (
        .tgt     (tgt),
        .rd_wide (rd_wide),
        .fold_en (cfg_inh),
        .ent0    (ent_val[0]),
        .ent1    (ent_val[1]),
        .ctl     (ctl_eff),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/pgprot_chk.sv
module pgprot_chk
    import pgprot_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_wide,
    input logic [AREG_W-1:0] addr_reg,
    input logic [ASEL_W-1:0] addr_sel,
    input logic [XLEN-1:0]   wr_data,
    input logic              rd_wide,
    input logic              rev_new,
    input logic [XLEN-1:0]   rd_data
);

    logic is_e0, is_e1, is_ctl, is_none;
    assign is_e0   = (addr_reg == REG_ENT0) && (addr_sel == SEL_ENT);
    assign is_e1   = (addr_reg == REG_ENT1) && (addr_sel == SEL_ENT);
    assign is_ctl  = (addr_reg == REG_CTL)  && (addr_sel == SEL_CTL);
    assign is_none = !is_e0 && !is_e1 && !is_ctl;

    // R7
    narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_wide |-> (rd_data[XLEN-1:CTL_W] == {(XLEN-CTL_W){rd_data[CTL_W-1]}}));

    // R4
    fixed_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_new && is_ctl) |-> (rd_data[RIE_POS:XIE_POS] == 2'b11));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_none |-> (rd_data == '0));

    // R5
    entry_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_e0 || is_e1) && rd_wide) |-> (rd_data[XLEN-INH_W-1:LOW_W] == '0));

    // R6
    wide_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_e0 && rd_wide && $past(rst_n) && $past(wr_en && wr_wide && is_e0))
        |-> ((rd_data & ~$past(wr_data)) == '0));

    // R5
    narrow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_e1 && rd_wide && $past(rst_n) && $past(wr_en && !wr_wide && is_e1))
        |-> (rd_data[LOW_W-1:0] == $past(wr_data[LOW_W-1:0])));

endmodule

bind pgprot_regs pgprot_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_wide  (wr_wide),
    .addr_reg (addr_reg),
    .addr_sel (addr_sel),
    .wr_data  (wr_data),
    .rd_wide  (rd_wide),
    .rev_new  (rev_new),
    .rd_data  (rd_data)
);

// File: tb/pgprot_regs_tb.sv
module pgprot_regs_tb;

    localparam logic [31:0] TB_RST = 32'h0000_0003;
    localparam logic [31:0] TB_WM  = 32'h1800_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_wide, rd_wide, cfg_inh, rev_new;
    logic [4:0]  addr_reg;
    logic [2:0]  addr_sel;
    logic [63:0] wr_data, rd_data;

    int total = 0;
    int bad   = 0;
    logic chk_vld = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } sb_t;
    sb_t sbq[$];

    logic [31:0] m_ctl;
    logic [63:0] m_ent [2];

    always #10 clk = ~clk;

    pgprot_regs #(.CTL_RESET(TB_RST), .CTL_WMASK(TB_WM)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
        .addr_reg(addr_reg), .addr_sel(addr_sel), .wr_data(wr_data),
        .rd_wide(rd_wide), .cfg_inh(cfg_inh), .rev_new(rev_new), .rd_data(rd_data)
    );

    function automatic logic [31:0] m_eff();
        return rev_new ? (m_ctl | 32'hC000_0000) : m_ctl;
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic int m_idx(input logic [4:0] r, input logic [2:0] s);
        if (r == 5'd2 && s == 3'd0) return 0;
        if (r == 5'd3 && s == 3'd0) return 1;
        if (r == 5'd5 && s == 3'd1) return 2;
        return 3;
    endfunction

    function automatic logic [63:0] m_read(input logic [4:0] r, input logic [2:0] s, input logic w);
        int k;
        logic [63:0] e;
        logic [31:0] n;
        k = m_idx(r, s);
        if (k == 2) return sx(m_eff());
        if (k == 3) return 64'd0;
        e = m_ent[k];
        if (w) return e;
        n = e[31:0];
        if (cfg_inh) n[31:30] = n[31:30] | e[63:62];
        return sx(n);
    endfunction

    task automatic m_write(input logic [4:0] r, input logic [2:0] s, input logic w, input logic [63:0] d);
        int k;
        logic [31:0] msk, en;
        logic [63:0] e;
        logic [1:0] hi;
        k = m_idx(r, s);
        en = m_eff();
        if (k == 2) begin
            msk = TB_WM & 32'h3FFF_FFFF;
            if (!rev_new && cfg_inh) msk = msk | 32'hC000_0000;
            m_ctl = (d[31:0] & msk) | (m_ctl & ~msk);
        end else if (k < 2) begin
            e = 64'd0;
            e[29:0] = d[29:0];
            hi = w ? d[63:62] : d[31:30];
            e[63] = hi[1] & en[31];
            e[62] = hi[0] & en[30];
            m_ent[k] = e;
        end
    endtask

    // driver: one bus cycle; expected value is taken before the model commits the write
    task automatic op(input logic we, input logic ww, input logic [4:0] r, input logic [2:0] s,
                      input logic [63:0] d, input logic rw, input logic chk, input string tag);
        sb_t it;
        @(negedge clk);
        wr_en = we; wr_wide = ww; addr_reg = r; addr_sel = s; wr_data = d; rd_wide = rw;
        chk_vld = chk;
        if (chk) begin
            it.exp = m_read(r, s, rw);
            it.tag = tag;
            sbq.push_back(it);
        end
        if (we) m_write(r, s, ww, d);
    endtask

    task automatic rd(input logic [4:0] r, input logic [2:0] s, input logic rw, input string tag);
        op(1'b0, 1'b0, r, s, 64'h0123_4567_89AB_CDEF, rw, 1'b1, tag);
    endtask

    task automatic wr(input logic [4:0] r, input logic [2:0] s, input logic ww, input logic [63:0] d);
        op(1'b1, ww, r, s, d, 1'b0, 1'b0, "");
    endtask

    task automatic mode(input logic rv, input logic sup);
        @(negedge clk);
        wr_en = 1'b0; chk_vld = 1'b0;
        rev_new = rv; cfg_inh = sup;
    endtask

    // monitor: compares away from the active edge
    initial begin
        sb_t it;
        forever begin
            @(negedge clk);
            #5;
            if (chk_vld) begin
                total++;
                if (sbq.size() == 0) begin
                    bad++;
                    $display("FAIL scoreboard empty: actual=%h expected=none", rd_data);
                end else begin
                    it = sbq.pop_front();
                    if (rd_data !== it.exp) begin
                        bad++;
                        $display("FAIL %s: actual=%h expected=%h", it.tag, rd_data, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_wide = 1'b0; rd_wide = 1'b0;
        cfg_inh = 1'b1; rev_new = 1'b0; addr_reg = '0; addr_sel = '0; wr_data = '0;
        m_ctl = TB_RST; m_ent[0] = '0; m_ent[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(5'd5, 3'd1, 1'b0, "R1 ctl reset");
        rd(5'd2, 3'd0, 1'b1, "R1 entry0 reset");
        rd(5'd3, 3'd0, 1'b1, "R1 entry1 reset");

        // older profile with support: enables writable, mask respected, sign-extended read
        wr(5'd5, 3'd1, 1'b0, 64'h0000_0000_FFFF_FFFF);
        rd(5'd5, 3'd1, 1'b0, "R2 R3 R11 ctl all-ones write");
        rd(5'd5, 3'd1, 1'b1, "R11 ctl wide read");

        // 32-bit move with both enables set
        wr(5'd2, 3'd0, 1'b0, 64'hFFFF_FFFF_C123_4567);
        rd(5'd2, 3'd0, 1'b1, "R5 R8 entry0 wide after narrow move");
        rd(5'd2, 3'd0, 1'b0, "R7 entry0 narrow folded");
        mode(1'b0, 1'b0);
        rd(5'd2, 3'd0, 1'b0, "R7 entry0 narrow no fold");
        mode(1'b0, 1'b1);

        // only execute-inhibit enabled
        wr(5'd5, 3'd1, 1'b0, 64'h0000_0000_4000_0000);
        rd(5'd5, 3'd1, 1'b0, "R3 ctl xi only");
        wr(5'd3, 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(5'd3, 3'd0, 1'b1, "R6 entry1 wide move gated");
        rd(5'd3, 3'd0, 1'b0, "R7 entry1 narrow fold xi");
        wr(5'd3, 3'd0, 1'b0, 64'h0000_0000_8000_0001);
        rd(5'd3, 3'd0, 1'b1, "R5 entry1 narrow ri gated off");

        // same-cycle write/read returns old value
        op(1'b1, 1'b1, 5'd2, 3'd0, 64'h0000_0000_0000_0000, 1'b1, 1'b1, "R10 read during write");
        rd(5'd2, 3'd0, 1'b1, "R10 value after write");

        // unmapped addresses
        wr(5'd2, 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(5'd2, 3'd1, 1'b1, "R9 unmapped read");
        rd(5'd2, 3'd0, 1'b1, "R9 entry0 untouched");
        rd(5'd5, 3'd0, 1'b0, "R9 reg5 sel0 zero");
        rd(5'd5, 3'd1, 1'b0, "R9 ctl untouched");

        // newer profile: enables fixed at one
        mode(1'b1, 1'b1);
        rd(5'd5, 3'd1, 1'b0, "R4 ctl forced ones");
        wr(5'd5, 3'd1, 1'b0, 64'h0000_0000_0000_0000);
        rd(5'd5, 3'd1, 1'b0, "R4 ctl write ignored on enables");
        wr(5'd2, 3'd0, 1'b0, 64'h0000_0000_C000_0000);
        rd(5'd2, 3'd0, 1'b1, "R4 R5 gating uses forced ones");

        // older profile without support: enables hold, other masked bits still writable
        mode(1'b0, 1'b0);
        wr(5'd5, 3'd1, 1'b0, 64'h0000_0000_D800_0000);
        rd(5'd5, 3'd1, 1'b0, "R2 R3 ctl enables hold without support");
        wr(5'd5, 3'd1, 1'b0, 64'h0000_0000_0000_0000);
        rd(5'd5, 3'd1, 1'b1, "R2 ctl masked bits cleared");

        @(negedge clk);
        chk_vld = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            bad++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sbq.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule